// File: doc/BRIEF.md
# Next-PC, Immediate and Link Unit

This block sits in the fetch/decode path of a single-issue 32-bit core and holds the program counter. Each cycle it looks at the instruction word, the current PC and the two source register values. From these it works out four things: the PC for the next cycle, the extended immediate, the base-plus-offset data address, and the return-address write for the link instructions. The register file, data memory and main ALU live outside it.

The PC is a register that follows the computed next PC on every rising clock edge. All other outputs are combinational functions of the current PC and the inputs. A link write's data therefore comes from the incremented PC of the same cycle in which control is redirected.

Control flow covers:
- straight-line execution;
- the two compare-and-branch forms, whose offsets are relative to the incremented PC;
- the two absolute jumps, which stay in the 256 MiB region of the incremented PC;
- the two jumps through a register.

Top module: `pc_steer_unit`

## Requirements
- R1: While `rst_n` is low the PC reads `RESET_PC` (default 0). After reset, on each rising clock edge the PC takes the value `next_pc` had before that edge.
- R2: Any instruction that is not a branch or jump listed below gives `next_pc = pc + 4`.
- R3: Opcode 0x04 (branch-if-equal) is taken when `rs_val - rt_val` is zero, and then `next_pc = pc + 4 + (sign-extended instr[15:0] << 2)`. Otherwise `next_pc = pc + 4`.
- R4: Opcode 0x05 (branch-if-not-equal) is taken when `rs_val - rt_val` is non-zero, with the same target as R3. Otherwise `next_pc = pc + 4`.
- R5: Opcode 0x02 (jump) gives `next_pc = {(pc+4)[31:28], instr[25:0], 2'b00}` and asserts no link write.
- R6: Opcode 0x03 (jump-and-link) jumps as in R5. It also sets `link_we` = 1, `link_reg` = 31 and `link_data = pc + 4`.
- R7: Opcode 0 with funct (instr[5:0]) 0x08 (jump-register) gives `next_pc = rs_val` and `link_we` = 0.
- R8: Opcode 0 with funct 0x09 (jump-register-and-link) gives `next_pc = rs_val`. It also sets `link_we` = 1, `link_reg = instr[15:11]` and `link_data = pc + 4`.
- R9: `imm_ext` is instr[15:0] zero-extended when the opcode is 0x0B (unsigned set-less-than immediate), and sign-extended for every other opcode.
- R10: `mem_addr = rs_val + sign-extended instr[15:0]` (two's complement, modulo 2^32). This is the address for loads (opcode 0x23) and stores (opcode 0x2B).
- R11: `link_we` is 0 for every instruction other than those of R6 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word of the current cycle |
| rs_val | input | 32 | Value of the first source register (bits 25:21) |
| rt_val | input | 32 | Value of the second source register (bits 20:16) |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Program counter for the next cycle |
| imm_ext | output | 32 | Extended 16-bit immediate |
| mem_addr | output | 32 | Base-plus-offset data address |
| link_we | output | 1 | Return-address write enable |
| link_reg | output | 5 | Destination register of the return address |
| link_data | output | 32 | Return address (incremented PC) |

## Verification
The branch forms are tried with equal and unequal operands and with positive and negative offsets. This separates a wrong condition polarity from a missing sign extension or a missing shift of the offset.

Absolute jumps are issued from a PC with non-zero upper bits and from the last word of the address space. That shows whether the region comes from the incremented PC rather than the current one.

Immediates with bit 15 set are fed to the unsigned compare, to an ordinary arithmetic op and to a load. This shows where zero versus sign extension applies. Load and store offsets at both signed extremes check the address adder.

// File: rtl/psu_pkg.sv
package psu_pkg;
  localparam int unsigned XW       = 32;
  localparam int unsigned OPC_W    = 6;
  localparam int unsigned FN_W     = 6;
  localparam int unsigned REG_W    = 5;
  localparam int unsigned IMM_W    = 16;
  localparam int unsigned TGT_W    = 26;
  localparam int unsigned REGION_W = XW - TGT_W - 2;
  localparam int unsigned STEP     = 4;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JMP     = 6'h02;
  localparam logic [OPC_W-1:0] OPC_JMPL    = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BREQ    = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BRNE    = 6'h05;
  localparam logic [OPC_W-1:0] OPC_SLTU_I  = 6'h0B;
  localparam logic [OPC_W-1:0] OPC_LOAD    = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE   = 6'h2B;
  localparam logic [FN_W-1:0]  FN_JREG     = 6'h08;
  localparam logic [FN_W-1:0]  FN_JREGL    = 6'h09;
  localparam logic [REG_W-1:0] RA_IDX      = 5'd31;

  typedef enum logic [1:0] {
    FLOW_SEQ  = 2'd0,
    FLOW_BR   = 2'd1,
    FLOW_ABS  = 2'd2,
    FLOW_REG  = 2'd3
  } flow_e;

  typedef struct packed {
    flow_e flow;
    logic  br_ne;
    logic  link_we;
    logic  link_ra;
    logic  zext;
  } ctl_t;
endpackage

// File: rtl/psu_decode.sv
module psu_decode
  import psu_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [FN_W-1:0]  fn,
  output ctl_t             ctl
);
  always_comb begin
    ctl         = '0;
    ctl.flow    = FLOW_SEQ;
    unique case (opc)
      OPC_SPECIAL: begin
        if (fn == FN_JREG) begin
          ctl.flow = FLOW_REG;
        end else if (fn == FN_JREGL) begin
          ctl.flow    = FLOW_REG;
          ctl.link_we = 1'b1;
        end
      end
      OPC_JMP:  ctl.flow = FLOW_ABS;
      OPC_JMPL: begin
        ctl.flow    = FLOW_ABS;
        ctl.link_we = 1'b1;
        ctl.link_ra = 1'b1;
      end
      OPC_BREQ: ctl.flow = FLOW_BR;
      OPC_BRNE: begin
        ctl.flow  = FLOW_BR;
        ctl.br_ne = 1'b1;
      end
      OPC_SLTU_I: ctl.zext = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/psu_operand.sv
module psu_operand
  import psu_pkg::*;
#(
  parameter bit CMP_BY_SUB = 1'b1
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [XW-1:0]    rs_val,
  input  logic [XW-1:0]    rt_val,
  input  logic             zext,
  output logic [XW-1:0]    imm_sx,
  output logic [XW-1:0]    imm_ext,
  output logic [XW-1:0]    mem_addr,
  output logic             equal
);
  localparam int unsigned PAD_W = XW - IMM_W;

  always_comb begin
    imm_sx   = {{PAD_W{imm[IMM_W-1]}}, imm};
    imm_ext  = zext ? {{PAD_W{1'b0}}, imm} : imm_sx;
    mem_addr = rs_val + imm_sx;
  end

  generate
    if (CMP_BY_SUB) begin : g_sub_cmp
      logic [XW-1:0] diff;
      always_comb begin
        diff  = rs_val - rt_val;
        equal = (diff == '0);
      end
    end else begin : g_xor_cmp
      always_comb equal = ~|(rs_val ^ rt_val);
    end
  endgenerate
endmodule

// File: rtl/psu_target.sv
module psu_target
  import psu_pkg::*;
(
  input  logic [XW-1:0]    pc,
  input  logic [TGT_W-1:0] tgt,
  input  logic [XW-1:0]    imm_sx,
  input  logic [XW-1:0]    rs_val,
  input  logic             equal,
  input  ctl_t             ctl,
  output logic [XW-1:0]    pc_inc,
  output logic [XW-1:0]    next_pc
);
  logic [XW-1:0] br_tgt;
  logic [XW-1:0] abs_tgt;
  logic          taken;

  always_comb begin
    pc_inc  = pc + XW'(STEP);
    br_tgt  = pc_inc + {imm_sx[XW-3:0], 2'b00};
    abs_tgt = {pc_inc[XW-1 -: REGION_W], tgt, 2'b00};
    taken   = equal ^ ctl.br_ne;
    unique case (ctl.flow)
      FLOW_BR:  next_pc = taken ? br_tgt : pc_inc;
      FLOW_ABS: next_pc = abs_tgt;
      FLOW_REG: next_pc = rs_val;
      default:  next_pc = pc_inc;
    endcase
  end
endmodule

// File: rtl/psu_pc_reg.sv
module psu_pc_reg
  import psu_pkg::*;
#(
  parameter logic [XW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] pc_d,
  output logic [XW-1:0] pc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
    end else begin
      pc_q <= pc_d;
    end
  end
endmodule

// File: rtl/pc_steer_unit.sv
module pc_steer_unit
  import psu_pkg::*;
#(
  parameter logic [XW-1:0] RESET_PC   = '0,
  parameter bit            CMP_BY_SUB = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XW-1:0]    instr,
  input  logic [XW-1:0]    rs_val,
  input  logic [XW-1:0]    rt_val,
  output logic [XW-1:0]    pc,
  output logic [XW-1:0]    next_pc,
  output logic [XW-1:0]    imm_ext,
  output logic [XW-1:0]    mem_addr,
  output logic             link_we,
  output logic [REG_W-1:0] link_reg,
  output logic [XW-1:0]    link_data
);
  ctl_t          ctl;
  logic [XW-1:0] imm_sx;
  logic [XW-1:0] pc_inc;
  logic          equal;

  psu_decode u_dec (
    .opc (instr[XW-1 -: OPC_W]),
    .fn  (instr[FN_W-1:0]),
    .ctl (ctl)
  );

  psu_operand #(.CMP_BY_SUB(CMP_BY_SUB)) u_opnd (
    .imm      (instr[IMM_W-1:0]),
    .rs_val   (rs_val),
    .rt_val   (rt_val),
    .zext     (ctl.zext),
    .imm_sx   (imm_sx),
    .imm_ext  (imm_ext),
    .mem_addr (mem_addr),
    .equal    (equal)
  );

  psu_target u_tgt (
    .pc      (pc),
    .tgt     (instr[TGT_W-1:0]),
    .imm_sx  (imm_sx),
    .rs_val  (rs_val),
    .equal   (equal),
    .ctl     (ctl),
    .pc_inc  (pc_inc),
    .next_pc (next_pc)
  );

  psu_pc_reg #(.RESET_PC(RESET_PC)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .pc_d  (next_pc),
    .pc_q  (pc)
  );

  always_comb begin
    link_we   = ctl.link_we;
    link_reg  = ctl.link_ra ? RA_IDX : instr[15:11];
    link_data = pc_inc;
  end
endmodule

// File: rtl/pc_steer_unit_chk.sv
module pc_steer_unit_chk
  import psu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [XW-1:0]    instr,
  input logic [XW-1:0]    rs_val,
  input logic [XW-1:0]    pc,
  input logic [XW-1:0]    next_pc,
  input logic [XW-1:0]    imm_ext,
  input logic             link_we,
  input logic [REG_W-1:0] link_reg,
  input logic [XW-1:0]    link_data
);
  logic [OPC_W-1:0] op;
  logic [FN_W-1:0]  fn;
  logic is_jr, is_jalr, is_jal, is_ctl;

  always_comb begin
    op      = instr[31:26];
    fn      = instr[5:0];
    is_jr   = (op == OPC_SPECIAL) && (fn == FN_JREG);
    is_jalr = (op == OPC_SPECIAL) && (fn == FN_JREGL);
    is_jal  = (op == OPC_JMPL);
    is_ctl  = is_jr || is_jalr || is_jal || (op == OPC_JMP) ||
              (op == OPC_BREQ) || (op == OPC_BRNE);
  end

  p_pc_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pc == $past(next_pc)));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !is_ctl |-> (next_pc == pc + 32'd4));

  p_jal_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_jal |-> (link_we && link_reg == RA_IDX && link_data == pc + 32'd4));

  p_jr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_jr |-> (next_pc == rs_val && !link_we));

  p_jalr_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_jalr |-> (link_we && link_reg == instr[15:11] && next_pc == rs_val));

  p_imm_zext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OPC_SLTU_I) |-> (imm_ext[31:16] == 16'h0000));

  p_no_link_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_jal || is_jalr) |-> !link_we);
endmodule

bind pc_steer_unit pc_steer_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .instr     (instr),
  .rs_val    (rs_val),
  .pc        (pc),
  .next_pc   (next_pc),
  .imm_ext   (imm_ext),
  .link_we   (link_we),
  .link_reg  (link_reg),
  .link_data (link_data)
);

// File: tb/pc_steer_unit_test.sv
module pc_steer_unit_test;
  logic        clk;
  logic        rst_n;
  logic [31:0] instr, rs_val, rt_val;
  logic [31:0] pc, next_pc, imm_ext, mem_addr, link_data;
  logic        link_we;
  logic [4:0]  link_reg;
  int checks = 0;
  int errors = 0;

  pc_steer_unit uut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .pc(pc), .next_pc(next_pc), .imm_ext(imm_ext), .mem_addr(mem_addr),
    .link_we(link_we), .link_reg(link_reg), .link_data(link_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rtype(input logic [4:0] rs, input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, 5'd0, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] itype(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd1, 5'd2, imm};
  endfunction
  function automatic logic [31:0] sx(input logic [15:0] imm);
    return {{16{imm[15]}}, imm};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_pc(input logic [31:0] v);
    instr  = rtype(5'd1, 5'd0, 6'h08);
    rs_val = v;
    tick();
  endtask

  task automatic test_reset();
    rst_n = 1'b0; instr = itype(6'h02, 16'h1234); rs_val = 0; rt_val = 0;
    #1 chk("R1 reset pc", pc, 32'h0);
    tick(); tick();
    chk("R1 pc held in reset", pc, 32'h0);
    instr = 32'h0;
    rst_n = 1'b1;
    tick();
    chk("R1 first step", pc, 32'h4);
  endtask

  task automatic test_seq();
    set_pc(32'h0000_2000);
    instr = {6'h00, 5'd3, 5'd4, 5'd5, 5'd0, 6'h20};
    #1;
    chk("R2 next pc", next_pc, 32'h0000_2004);
    chk("R11 no link add", {31'b0, link_we}, 32'h0);
    tick();
    chk("R2 pc advanced", pc, 32'h0000_2004);
  endtask

  task automatic test_branch(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                             input logic [15:0] imm, input bit taken, input string tag);
    logic [31:0] exp;
    set_pc(32'h0000_1000);
    instr = itype(op, imm); rs_val = a; rt_val = b;
    exp = taken ? (32'h0000_1004 + (sx(imm) << 2)) : 32'h0000_1004;
    #1;
    chk({tag, " next"}, next_pc, exp);
    chk("R11 no link branch", {31'b0, link_we}, 32'h0);
    tick();
    chk({tag, " pc"}, pc, exp);
  endtask

  task automatic test_jump(input logic [31:0] start, input bit link);
    logic [31:0] inc, exp;
    set_pc(start);
    instr = {link ? 6'h03 : 6'h02, 26'h0123456};
    inc = start + 32'd4;
    exp = {inc[31:28], 26'h0123456, 2'b00};
    #1;
    if (link) begin
      chk("R6 target", next_pc, exp);
      chk("R6 link we", {31'b0, link_we}, 32'h1);
      chk("R6 link reg", {27'b0, link_reg}, 32'd31);
      chk("R6 link data", link_data, inc);
    end else begin
      chk("R5 target", next_pc, exp);
      chk("R5 no link", {31'b0, link_we}, 32'h0);
    end
    tick();
    chk(link ? "R6 pc" : "R5 pc", pc, exp);
  endtask

  task automatic test_regjump();
    set_pc(32'h0000_3000);
    instr = rtype(5'd7, 5'd0, 6'h08); rs_val = 32'h1234_5678;
    #1;
    chk("R7 next", next_pc, 32'h1234_5678);
    chk("R7 no link", {31'b0, link_we}, 32'h0);
    tick();
    chk("R7 pc", pc, 32'h1234_5678);
    instr = rtype(5'd7, 5'd5, 6'h09); rs_val = 32'h0000_0400;
    #1;
    chk("R8 next", next_pc, 32'h0000_0400);
    chk("R8 link we", {31'b0, link_we}, 32'h1);
    chk("R8 link reg", {27'b0, link_reg}, 32'd5);
    chk("R8 link data", link_data, 32'h1234_567C);
    tick();
    chk("R8 pc", pc, 32'h0000_0400);
  endtask

  task automatic test_imm();
    instr = itype(6'h0B, 16'h8001); #1;
    chk("R9 sltiu zext", imm_ext, 32'h0000_8001);
    instr = itype(6'h08, 16'h8001); #1;
    chk("R9 addi sext", imm_ext, 32'hFFFF_8001);
    instr = itype(6'h0B, 16'h7FFF); #1;
    chk("R9 sltiu low", imm_ext, 32'h0000_7FFF);
    tick();
  endtask

  task automatic test_addr();
    rs_val = 32'h0000_1000;
    instr = itype(6'h23, 16'hFFFC); #1;
    chk("R10 load neg", mem_addr, 32'h0000_0FFC);
    chk("R9 load sext", imm_ext, 32'hFFFF_FFFC);
    instr = itype(6'h2B, 16'h7FFF); #1;
    chk("R10 store max", mem_addr, 32'h0000_8FFF);
    instr = itype(6'h2B, 16'h8000); rs_val = 32'h0000_0004; #1;
    chk("R10 store min wrap", mem_addr, 32'hFFFF_8004);
    chk("R11 no link store", {31'b0, link_we}, 32'h0);
    tick();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_seq();
    test_branch(6'h04, 32'd9, 32'd9, 16'h0010, 1'b1, "R3 beq taken fwd");
    test_branch(6'h04, 32'd9, 32'd9, 16'hFFFE, 1'b1, "R3 beq taken back");
    test_branch(6'h04, 32'd9, 32'd8, 16'h0010, 1'b0, "R3 beq not taken");
    test_branch(6'h05, 32'd1, 32'd2, 16'hFFF0, 1'b1, "R4 bne taken");
    test_branch(6'h05, 32'd5, 32'd5, 16'h0020, 1'b0, "R4 bne not taken");
    test_jump(32'hA000_0010, 1'b0);
    test_jump(32'hFFFF_FFFC, 1'b0);
    test_jump(32'h7000_0100, 1'b1);
    test_regjump();
    test_imm();
    test_addr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule